// File: doc/BRIEF.md
# Partial-Word Store-Bytes Unit

This unit turns one "store bytes" request into exactly one masked word operation on a big-endian 32-bit memory port. A request carries a byte address, a register value and a mode bit. In begin mode the unit stores the low-order bytes of the value from the addressed byte up to the end of the word. In end mode it stores the high-order bytes of the value into the bytes of the word that lie below the addressed byte. The two low address bits set how many bytes are stored.

The unit always presents the word-aligned address, a byte-enable mask and write data that is already in its lanes. Because every store leaves as a single masked write, a three-byte store is atomic at the memory port. An end-mode request whose address is word-aligned stores nothing. It still issues a probe strobe in place of the write, so the memory side can check protection and mark the line dirty.

Requests use a valid/ready handshake with at most one command in flight. The command is registered and is held on the memory port until the port accepts it.

Top module: `sbu_store_bytes`

## Requirements
- R1: After reset, both memory strobes are low and `req_ready` is high.
- R2: In begin mode (`req_end` = 0) with offset k (address bits [1:0]), the lanes at byte offsets k through 3 are enabled. Byte offset i maps to `mem_be` bit 3-i, so bit 3 is offset 0, the most significant lane.
- R3: In end mode (`req_end` = 1) with offset k > 0, the lanes at byte offsets 0 through k-1 are enabled, using the same mapping from offset to `mem_be` bit.
- R4: An end-mode request with offset 0 raises `mem_probe` with `mem_be` = 0 and does not raise `mem_wr`.
- R5: `mem_addr` equals the request address with its two low bits cleared, in every mode.
- R6: Each enabled lane of `mem_wdata` carries the byte of `req_data` in the same bit position (offset 0 is bits 31:24). Disabled lanes are zero.
- R7: Each accepted request produces exactly one strobe cycle when `mem_ready` is high. This includes the three-byte cases (begin offset 1, end offset 3).
- R8: While a command is held, `req_ready` is low. If `mem_ready` is low, the strobe, address, mask and data stay unchanged, and a new request is not taken.
- R9: `mem_wr` and `mem_probe` are never high in the same cycle.
- R10: The command appears on the memory port in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| req_addr | input | 32 | Byte address |
| req_data | input | 32 | Register value to store |
| mem_wr | output | 1 | Masked write strobe |
| mem_probe | output | 1 | Zero-length write probe strobe |
| mem_ready | input | 1 | Memory port accepts the command |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Byte enables; bit 3 is offset 0 |
| mem_wdata | output | 32 | Lane-aligned write data |

## Verification
The assertions assume that the memory side obeys the handshake: once a strobe is up, the command changes only after `mem_ready` has been sampled high. They also assume that requests are presented only with a defined mode bit and address. The bench drives every input at the falling clock edge and keeps them defined at all times. It raises `mem_ready` only in the stall scenario, and then only after the stalled command has been inspected. Stimulus covers every offset in both modes with several data patterns. It also lowers `mem_ready` while a second request is pending, to check that nothing leaks into the held command.

// File: rtl/sbu_pkg.sv
// Shared types for the store-bytes unit.
// Assumes a big-endian word: byte offset 0 sits in the most significant lane.
package sbu_pkg;
    typedef enum logic {
        SBU_BEGIN = 1'b0,
        SBU_END   = 1'b1
    } sbu_mode_e;
endpackage

// File: rtl/sbu_lane_mask.sv
// Lane-mask decoder: turns mode and word offset into byte enables.
// Assumes LANES is a power of two and that bit LANES-1-i of the mask
// belongs to byte offset i (most significant lane = offset 0).
module sbu_lane_mask
    import sbu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  sbu_mode_e          mode,
    input  logic [OFF_W-1:0]   offset,
    output logic [LANES-1:0]   mask,
    output logic               zero_len
);
    // One enable per byte offset; begin keeps offsets >= k, end keeps offsets < k.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (mode == SBU_END) begin
                mask[LANES-1-i] = (OFF_W'(i) < offset);
            end else begin
                mask[LANES-1-i] = (OFF_W'(i) >= offset);
            end
        end
    end

    // An end-mode store at offset 0 carries no bytes.
    always_comb zero_len = (mode == SBU_END) && (offset == '0);
endmodule

// File: rtl/sbu_lane_data.sv
// Lane data gate: passes each byte lane whose enable is set and zeroes the rest.
// Assumes the register value is already in memory byte order, so no shift is needed.
module sbu_lane_data #(
    parameter int LANES = 4,
    localparam int DW = LANES * 8
) (
    input  logic [DW-1:0]    data_in,
    input  logic [LANES-1:0] mask,
    output logic [DW-1:0]    data_out
);
    // Gate each byte by its own enable bit.
    for (genvar b = 0; b < LANES; b++) begin : g_byte
        always_comb data_out[b*8 +: 8] = mask[b] ? data_in[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sbu_cmd_hold.sv
// Command holding register: captures one command and presents it on the
// memory port until the port takes it. Assumes load is asserted only while busy is low.
module sbu_cmd_hold #(
    parameter int AW    = 32,
    parameter int LANES = 4,
    localparam int DW = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             in_probe,
    input  logic [AW-1:0]    in_addr,
    input  logic [LANES-1:0] in_be,
    input  logic [DW-1:0]    in_data,
    input  logic             out_ready,
    output logic             busy,
    output logic             out_wr,
    output logic             out_probe,
    output logic [AW-1:0]    out_addr,
    output logic [LANES-1:0] out_be,
    output logic [DW-1:0]    out_data
);
    logic             vld_q;
    logic             probe_q;
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    data_q;

    // Valid flag: set on load, cleared once the port accepts the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (load) begin
            vld_q <= 1'b1;
        end else if (vld_q && out_ready) begin
            vld_q <= 1'b0;
        end
    end

    // Command fields: captured only on load and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            data_q  <= '0;
        end else if (load) begin
            probe_q <= in_probe;
            addr_q  <= in_addr;
            be_q    <= in_be;
            data_q  <= in_data;
        end
    end

    // Port view: the single valid bit is split into the two strobes.
    always_comb begin
        busy      = vld_q;
        out_wr    = vld_q && !probe_q;
        out_probe = vld_q && probe_q;
        out_addr  = addr_q;
        out_be    = be_q;
        out_data  = data_q;
    end

    // R8: a stalled command keeps its contents and its strobe.
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !out_ready) |=> (vld_q && $stable(addr_q) && $stable(be_q)
                                   && $stable(data_q) && $stable(probe_q)));

    // R8: no capture while a command is held.
    p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> !load);
endmodule

// File: rtl/sbu_store_bytes.sv
// Store-bytes unit top: decodes one begin/end store-bytes request into a
// single masked word write, or into a write probe when no bytes are stored.
// Assumes a big-endian memory port that takes one command at a time.
module sbu_store_bytes
    import sbu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 4,
    localparam int DW    = LANES * 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_end,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    output logic             mem_wr,
    output logic             mem_probe,
    input  logic             mem_ready,
    output logic [AW-1:0]    mem_addr,
    output logic [LANES-1:0] mem_be,
    output logic [DW-1:0]    mem_wdata
);
    sbu_mode_e        mode;
    logic [OFF_W-1:0] offset;
    logic [LANES-1:0] be_d;
    logic             zero_d;
    logic [DW-1:0]    data_d;
    logic [AW-1:0]    addr_d;
    logic             busy;
    logic             accept;

    // Request decode: mode, offset, aligned address and handshake.
    always_comb begin
        mode      = sbu_mode_e'(req_end);
        offset    = req_addr[OFF_W-1:0];
        addr_d    = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
        req_ready = !busy;
        accept    = req_valid && !busy;
    end

    sbu_lane_mask #(.LANES(LANES)) mask_i (
        .mode     (mode),
        .offset   (offset),
        .mask     (be_d),
        .zero_len (zero_d)
    );

    sbu_lane_data #(.LANES(LANES)) data_i (
        .data_in  (req_data),
        .mask     (be_d),
        .data_out (data_d)
    );

    sbu_cmd_hold #(.AW(AW), .LANES(LANES)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .in_probe  (zero_d),
        .in_addr   (addr_d),
        .in_be     (be_d),
        .in_data   (data_d),
        .out_ready (mem_ready),
        .busy      (busy),
        .out_wr    (mem_wr),
        .out_probe (mem_probe),
        .out_addr  (mem_addr),
        .out_be    (mem_be),
        .out_data  (mem_wdata)
    );

    // R9: the two strobes never coincide.
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_probe));

    // R4: a probe carries an empty mask; a write carries at least one lane.
    p_probe_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_probe |-> (mem_be == '0));
    p_write_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_be != '0));

    // R5: the port address is word-aligned whenever a strobe is up.
    p_addr_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_probe) |-> (mem_addr[OFF_W-1:0] == '0));

    // R10: an accepted request shows up as a strobe on the next cycle.
    p_issue_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_wr || mem_probe));

    // R8: the unit refuses requests while a strobe is up.
    p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_probe) |-> !req_ready);
endmodule

// File: tb/sbu_store_bytes_tb.sv
// Directed bench for the store-bytes unit; one task per scenario.
module sbu_store_bytes_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_end = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        mem_wr;
    logic        mem_probe;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sbu_store_bytes dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_end(req_end),
        .req_addr(req_addr), .req_data(req_data),
        .mem_wr(mem_wr), .mem_probe(mem_probe), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Enables from R2/R3: offset i maps to bit 3-i.
    function automatic logic [3:0] want_be(input logic is_end, input int k);
        logic [3:0] m = '0;
        for (int i = 0; i < 4; i++) begin
            if (is_end ? (i < k) : (i >= k)) m[3-i] = 1'b1;
        end
        return m;
    endfunction

    // Data from R6: enabled lanes pass, others zero.
    function automatic logic [31:0] want_data(input logic [31:0] v, input logic [3:0] m);
        logic [31:0] d = '0;
        for (int b = 0; b < 4; b++) begin
            if (m[b]) d[b*8 +: 8] = v[b*8 +: 8];
        end
        return d;
    endfunction

    // One request with mem_ready high; checks the next cycle and the cycle after.
    task automatic issue(input logic is_end, input logic [31:0] a, input logic [31:0] v,
                         input string tag);
        logic [3:0] eb;
        int k;
        k  = int'(a[1:0]);
        eb = want_be(is_end, k);
        @(negedge clk);
        req_valid = 1'b1; req_end = is_end; req_addr = a; req_data = v;
        @(negedge clk);
        req_valid = 1'b0;
        if (is_end && k == 0) begin
            chk({tag, " R4 probe"}, mem_probe, 1);
            chk({tag, " R4 R9 no write"}, mem_wr, 0);
        end else begin
            chk({tag, " R10 write next cycle"}, mem_wr, 1);
            chk({tag, " R9 no probe"}, mem_probe, 0);
        end
        chk({tag, is_end ? " R3 be" : " R2 be"}, mem_be, eb);
        chk({tag, " R5 addr"}, mem_addr, {a[31:2], 2'b00});
        chk({tag, " R6 data"}, mem_wdata, want_data(v, eb));
        chk({tag, " R8 ready low while held"}, req_ready, 0);
        @(negedge clk);
        chk({tag, " R7 single strobe"}, mem_wr | mem_probe, 0);
        chk({tag, " R7 ready back"}, req_ready, 1);
    endtask

    task automatic t_reset();
        chk("R1 wr at reset", mem_wr, 0);
        chk("R1 probe at reset", mem_probe, 0);
        chk("R1 ready at reset", req_ready, 1);
    endtask

    task automatic t_begin();
        for (int k = 0; k < 4; k++) begin
            issue(1'b0, 32'h1000_0100 + 32'(k), 32'hA1B2_C3D4, "R2 begin");
            issue(1'b0, 32'hFFFF_FF00 + 32'(k), 32'h0102_0304 ^ 32'(k), "R2 begin alt");
        end
    endtask

    task automatic t_end();
        for (int k = 1; k < 4; k++) begin
            issue(1'b1, 32'h0000_2200 + 32'(k), 32'h5566_7788, "R3 end");
            issue(1'b1, 32'h8765_4320 + 32'(k), 32'hFFFF_FFFF, "R3 end ones");
        end
    endtask

    task automatic t_zero_len();
        issue(1'b1, 32'h0000_3004, 32'hDEAD_BEEF, "R4 zero length");
    endtask

    task automatic t_three_byte();
        issue(1'b0, 32'h0000_4001, 32'h00AB_CDEF, "R7 begin three");
        issue(1'b1, 32'h0000_4003, 32'hABCD_EF00, "R7 end three");
    endtask

    // Stall: memory not ready, second request pending, held command must not move.
    task automatic t_stall();
        @(negedge clk);
        mem_ready = 1'b0;
        req_valid = 1'b1; req_end = 1'b0; req_addr = 32'h0000_5002; req_data = 32'h1122_3344;
        @(negedge clk);
        req_end = 1'b1; req_addr = 32'h0000_6003; req_data = 32'h99AA_BBCC;
        chk("R10 stall write up", mem_wr, 1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R8 held strobe", mem_wr, 1);
            chk("R8 held addr", mem_addr, 32'h0000_5000);
            chk("R8 held be", mem_be, 4'b0011);
            chk("R8 held data", mem_wdata, 32'h0000_3344);
            chk("R8 ready low", req_ready, 0);
        end
        req_valid = 1'b0;
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R8 released", mem_wr | mem_probe, 0);
        chk("R8 ready after release", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_begin();
        t_end();
        t_zero_len();
        t_three_byte();
        t_stall();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule